// File: doc/BRIEF.md
# I2C Byte Shifter with Start, Stop and Acknowledge Framing

This block is the serial data path for one I2C byte and the acknowledge bit that follows it. A transmit section holds one byte in a buffer and moves it into a frame shifter once the shifter is idle. The shifter then drives SDA open-drain: it pulls the line low for a 0 and releases it for a 1. A receive section samples the resolved SDA line into a second shifter. Both sections advance on one-cycle strobes from an external bit timer. `shift_rise` moves the transmit frame on by one bit, and `shift_fall` takes a receive sample. The block does not generate SCL and does not count bytes.

Each frame has a low start bit, then the data bits most significant first, then a final framing bit. The final bit is the acknowledge slot. With `ack_en` high when the shifter takes the byte, the block drives that slot low, so the master acknowledges. With `ack_en` low it releases the slot, which gives a NAK. Every frame also fills the receive side, whether the master writes or reads. The sampled byte goes to a holding register and sets rx-full. A high sample in the acknowledge slot sets the NAK flag. To read a byte from a target, the sequencer loads all ones, which leaves SDA free for the target to drive.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, `status` is 3'b001 (bit0 tx-empty = 1, bit1 rx-full = 0, bit2 NAK = 0), `sda_oe` is 0 and `rx_byte` is 0.
- R2: A `tx_load` pulse stores `tx_byte` and clears tx-empty (status bit0) on the next cycle. When the shifter is idle, it takes the byte one cycle later and tx-empty returns to 1.
- R3: In the cycle after the takeover, the start bit is on the line: `sda_oe` = 1, meaning SDA is driven low.
- R4: The data bits go out most significant first, one bit per `shift_rise`. After the k-th rise, `sda_oe` equals the inverse of data bit DATA_W-k.
- R5: The `ack_en` value sampled at takeover sets the acknowledge slot. After rise DATA_W+1, `sda_oe` = 1 (drive low, ACK) if `ack_en` was 1, and `sda_oe` = 0 (release, NAK) if it was 0. Rise DATA_W+2 ends the frame and releases SDA.
- R6: A byte of all ones keeps SDA released through every data bit, so the received byte is exactly what the target drives.
- R7: The receive shifter takes one `sda_in` sample per `shift_fall` after each data rise, most significant first. The sample in the acknowledge slot copies the byte into `rx_byte` and sets rx-full (status bit1). `rx_byte` changes at no other time.
- R8: Every frame sets rx-full once, including frames the master writes. In such a frame `rx_byte` equals the wired-AND of the transmitted byte and the target's bits.
- R9: A high sample in the acknowledge slot sets NAK (status bit2). A low sample leaves NAK unchanged, and NAK stays set until it is cleared.
- R10: A `rx_read` pulse clears only rx-full, and a `nak_clr` pulse clears only NAK. A setting event in the same cycle wins over the clear.
- R11: A `shift_rise` while idle and a `shift_fall` during the start bit have no effect. A byte loaded while a frame is running waits, with tx-empty at 0, until that frame ends, and is then taken over on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_rise | input | 1 | One-cycle strobe from the bit timer that advances the transmit frame |
| shift_fall | input | 1 | One-cycle strobe from the bit timer that samples SDA |
| tx_load | input | 1 | Writes `tx_byte` into the transmit buffer |
| tx_byte | input | DATA_W | Byte to transmit |
| ack_en | input | 1 | 1: drive the acknowledge slot low; 0: release it |
| rx_read | input | 1 | Read strobe for `rx_byte`; clears rx-full |
| nak_clr | input | 1 | Clears the NAK flag |
| sda_in | input | 1 | Resolved SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| status | output | 3 | bit0 tx-empty, bit1 rx-full, bit2 NAK |
| rx_byte | output | DATA_W | Holding register for the last received byte |

## Verification
The bench builds the block with DATA_W = 8, which gives a ten-bit frame. That size lets a full frame run in a few dozen cycles, so the bench can drive many random frames and the complete set of acknowledge combinations: master ACK or NAK crossed with target pull or release. A model of the open-drain bus makes the received byte the AND of both drivers. This covers master writes, all-ones reads and mixed wired-AND contention. Directed frames check the start-bit-phase fall strobe, a load made during a running frame with a changed `ack_en`, and the sticky NAK flag together with its clear.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;
  localparam int ST_TXE = 0;
  localparam int ST_RXF = 1;
  localparam int ST_NAK = 2;
  localparam int ST_W   = 3;

  function automatic logic [ST_W-1:0] pack_status(input logic txe, input logic rxf,
                                                  input logic nak);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_TXE] = txe;
    s[ST_RXF] = rxf;
    s[ST_NAK] = nak;
    return s;
  endfunction

  // level of the trailing framing bit: low acknowledges, high refuses
  function automatic logic ack_slot_level(input logic ack_enable);
    return ~ack_enable;
  endfunction
endpackage

// File: rtl/i2cbs_tx.sv
module i2cbs_tx #(
  parameter int DATA_W     = 8,
  parameter int FRAME_BITS = DATA_W + 2,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_rise,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ack_en,
  output logic              tx_empty,
  output logic              active,
  output logic [CNT_W-1:0]  rise_cnt,
  output logic              take,
  output logic              frame_end,
  output logic              sda_oe
);
  import i2cbs_pkg::*;

  localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(FRAME_BITS - 1);

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] d,
                                                        input logic ack);
    return {1'b0, d, ack_slot_level(ack)};
  endfunction

  logic [DATA_W-1:0]     buf_q;
  logic [FRAME_BITS-1:0] shreg;

  assign take      = !active && !tx_empty;
  assign frame_end = active && shift_rise && (rise_cnt == LAST_RISE);
  assign sda_oe    = active && !shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      tx_empty <= 1'b1;
      shreg    <= '1;
      active   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      if (tx_load) begin
        buf_q    <= tx_byte;
        tx_empty <= 1'b0;
      end else if (take) begin
        tx_empty <= 1'b1;
      end

      if (take) begin
        shreg    <= build_frame(buf_q, ack_en);
        active   <= 1'b1;
        rise_cnt <= '0;
      end else if (active && shift_rise) begin
        shreg    <= {shreg[FRAME_BITS-2:0], 1'b1};
        rise_cnt <= rise_cnt + 1'b1;
        if (frame_end) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cbs_rx.sv
module i2cbs_rx #(
  parameter int DATA_W     = 8,
  parameter int FRAME_BITS = DATA_W + 2,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_fall,
  input  logic              active,
  input  logic [CNT_W-1:0]  rise_cnt,
  input  logic              take,
  input  logic              sda_in,
  input  logic              rx_read,
  input  logic              nak_clr,
  output logic [DATA_W-1:0] rx_hold,
  output logic              rx_full,
  output logic              nak,
  output logic              rx_done
);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(DATA_W);

  logic [CNT_W-1:0]  smp_cnt;
  logic [DATA_W-1:0] rx_sh;
  logic              sample;

  // one sample per rise already seen; the start-bit phase has none
  assign sample  = active && shift_fall && (smp_cnt < rise_cnt);
  assign rx_done = sample && (smp_cnt == ACK_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_cnt <= '0;
      rx_sh   <= '0;
      rx_hold <= '0;
      rx_full <= 1'b0;
      nak     <= 1'b0;
    end else begin
      if (take) begin
        smp_cnt <= '0;
      end else if (sample) begin
        smp_cnt <= smp_cnt + 1'b1;
        if (!rx_done) rx_sh <= {rx_sh[DATA_W-2:0], sda_in};
      end

      if (rx_done) begin
        rx_hold <= rx_sh;
        rx_full <= 1'b1;
      end else if (rx_read) begin
        rx_full <= 1'b0;
      end

      if (rx_done && sda_in) nak <= 1'b1;
      else if (nak_clr)      nak <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_rise,
  input  logic              shift_fall,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ack_en,
  input  logic              rx_read,
  input  logic              nak_clr,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [2:0]        status,
  output logic [DATA_W-1:0] rx_byte
);
  import i2cbs_pkg::*;

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  // named internal events, visible to the bound checker
  logic             take_ev;
  logic             frame_end;
  logic             rx_done;
  logic             tx_active;
  logic [CNT_W-1:0] rise_cnt;
  logic             tx_empty;
  logic             rx_full;
  logic             nak;

  i2cbs_tx #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .shift_rise(shift_rise), .tx_load(tx_load),
    .tx_byte(tx_byte), .ack_en(ack_en), .tx_empty(tx_empty), .active(tx_active),
    .rise_cnt(rise_cnt), .take(take_ev), .frame_end(frame_end), .sda_oe(sda_oe)
  );

  i2cbs_rx #(.DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .active(tx_active),
    .rise_cnt(rise_cnt), .take(take_ev), .sda_in(sda_in), .rx_read(rx_read),
    .nak_clr(nak_clr), .rx_hold(rx_byte), .rx_full(rx_full), .nak(nak),
    .rx_done(rx_done)
  );

  assign status = pack_status(tx_empty, rx_full, nak);
endmodule

// File: rtl/i2cbs_checker.sv
module i2cbs_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_load,
  input logic              rx_read,
  input logic              nak_clr,
  input logic              shift_rise,
  input logic              sda_in,
  input logic              sda_oe,
  input logic [2:0]        status,
  input logic [DATA_W-1:0] rx_byte,
  input logic              take_ev,
  input logic              rx_done,
  input logic              frame_end
);
  assert_load_clears_txe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !status[0]);

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> sda_oe);

  assert_sda_moves_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_rise && !take_ev) |=> $stable(sda_oe));

  assert_frame_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !sda_oe);

  assert_rx_full_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> status[1]);

  assert_rx_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(rx_byte));

  assert_nak_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && sda_in) |=> status[2]);

  assert_nak_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !nak_clr) |=> status[2]);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && !rx_done) |=> !status[1]);
endmodule

bind i2c_byte_shifter i2cbs_checker #(.DATA_W(DATA_W)) u_i2cbs_checker (
  .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .rx_read(rx_read), .nak_clr(nak_clr),
  .shift_rise(shift_rise), .sda_in(sda_in), .sda_oe(sda_oe), .status(status),
  .rx_byte(rx_byte), .take_ev(take_ev), .rx_done(rx_done), .frame_end(frame_end)
);

// File: tb/test_i2c_byte_shifter.sv
`timescale 1ns/1ps
module test_i2c_byte_shifter;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_rise = 1'b0, shift_fall = 1'b0, tx_load = 1'b0, ack_en = 1'b0;
  logic rx_read = 1'b0, nak_clr = 1'b0, tgt_low = 1'b0;
  logic [DW-1:0] tx_byte = '0;
  logic sda_in, sda_oe;
  logic [2:0] status;
  logic [DW-1:0] rx_byte;

  int checks = 0, failures = 0;
  bit done = 0;
  logic nak_m = 1'b0, rxf_m = 1'b0;
  logic [DW-1:0] rxb_m = '0;

  always #2.5 clk = ~clk;

  // open-drain bus: either driver pulls low
  assign sda_in = ~(sda_oe | tgt_low);

  i2c_byte_shifter #(.DATA_W(DW)) i_i2c_byte_shifter (
    .clk(clk), .rst_n(rst_n), .shift_rise(shift_rise), .shift_fall(shift_fall),
    .tx_load(tx_load), .tx_byte(tx_byte), .ack_en(ack_en), .rx_read(rx_read),
    .nak_clr(nak_clr), .sda_in(sda_in), .sda_oe(sda_oe), .status(status),
    .rx_byte(rx_byte)
  );

  function automatic logic [DW-1:0] exp_rx(input logic [DW-1:0] m, input logic [DW-1:0] t);
    return m & t;
  endfunction

  function automatic logic exp_ack_line(input logic master_ack, input logic target_low);
    return !(master_ack || target_low);
  endfunction

  function automatic logic exp_bit_oe(input logic [DW-1:0] d, input int k);
    return ~d[DW-k];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_rise();
    @(posedge clk); #1 shift_rise = 1'b1;
    @(posedge clk); #1 shift_rise = 1'b0;
  endtask

  task automatic pulse_fall();
    @(posedge clk); #1 shift_fall = 1'b1;
    @(posedge clk); #1 shift_fall = 1'b0;
  endtask

  task automatic do_read();
    @(posedge clk); #1 rx_read = 1'b1;
    @(posedge clk); #1 rx_read = 1'b0;
    rxf_m = 1'b0;
    chk("R10 rx_read clears rx-full only", {29'd0, status}, {29'd0, nak_m, 1'b0, 1'b1});
  endtask

  task automatic do_nak_clr();
    @(posedge clk); #1 nak_clr = 1'b1;
    @(posedge clk); #1 nak_clr = 1'b0;
    nak_m = 1'b0;
    chk("R10 nak_clr clears NAK only", {29'd0, status}, {29'd0, 1'b0, rxf_m, 1'b1});
  endtask

  task automatic run_frame(input logic [DW-1:0] d, input logic ack, input logic [DW-1:0] tgt,
                           input logic tack, input bit preloaded, input bit load_next,
                           input logic [DW-1:0] nd, input logic nack);
    if (!preloaded) begin
      @(posedge clk); #1 tx_load = 1'b1; tx_byte = d; ack_en = ack;
      @(posedge clk); #1 tx_load = 1'b0;
    end
    chk("R2 tx-empty low after load", {31'd0, status[0]}, 32'd0);
    @(posedge clk); #1;
    chk("R2 tx-empty back after takeover", {31'd0, status[0]}, 32'd1);
    chk("R3 start bit drives low", {31'd0, sda_oe}, 32'd1);
    pulse_fall();  // R11: must not be sampled
    chk("R11 start-phase fall no effect on line", {31'd0, sda_oe}, 32'd1);
    for (int k = 1; k <= DW + 1; k++) begin
      pulse_rise();
      if (k <= DW) begin
        chk("R4 data bit MSB first", {31'd0, sda_oe}, {31'd0, exp_bit_oe(d, k)});
        tgt_low = ~tgt[DW-k];
      end else begin
        chk("R5 ack slot level", {31'd0, sda_oe}, {31'd0, ack});
        tgt_low = tack;
      end
      if (load_next && k == 1) begin
        @(posedge clk); #1 tx_load = 1'b1; tx_byte = nd; ack_en = nack;
        @(posedge clk); #1 tx_load = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 load during frame waits", {31'd0, status[0]}, 32'd0);
        chk("R11 running frame undisturbed", {31'd0, sda_oe}, {31'd0, exp_bit_oe(d, 1)});
      end
      pulse_fall();
    end
    rxb_m = exp_rx(d, tgt);
    rxf_m = 1'b1;
    nak_m = nak_m | exp_ack_line(ack, tack);
    chk("R7 R8 rx-full set per frame", {31'd0, status[1]}, 32'd1);
    chk("R6 R7 R8 received byte", {24'd0, rx_byte}, {24'd0, rxb_m});
    chk("R9 NAK flag", {31'd0, status[2]}, {31'd0, nak_m});
    pulse_rise();
    tgt_low = 1'b0;
    chk("R5 frame end releases SDA", {31'd0, sda_oe}, 32'd0);
  endtask

  initial begin
    logic [DW-1:0] d, t;
    logic a, ta;
    void'($urandom(32'h5eed_1c2b));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", {29'd0, status}, 32'd1);
    chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 reset rx_byte", {24'd0, rx_byte}, 32'd0);

    pulse_rise();
    chk("R11 idle rise no effect sda", {31'd0, sda_oe}, 32'd0);
    chk("R11 idle rise no effect status", {29'd0, status}, 32'd1);

    // master write, target acks
    run_frame(8'hA5, 1'b0, 8'hFF, 1'b1, 0, 0, '0, 1'b0);
    do_read();
    // master read of target byte, master acks
    run_frame(8'hFF, 1'b1, 8'h3C, 1'b0, 0, 0, '0, 1'b0);
    // read of all ones with NAK from master on the last byte
    run_frame(8'hFF, 1'b0, 8'hFF, 1'b0, 0, 0, '0, 1'b0);
    // target refuses a written byte
    run_frame(8'h81, 1'b0, 8'hFF, 1'b0, 0, 0, '0, 1'b0);
    // NAK stays set across an acked frame
    run_frame(8'h00, 1'b0, 8'hFF, 1'b1, 0, 0, '0, 1'b0);
    do_nak_clr();
    // back-to-back: second byte loaded mid-frame with a different ack_en
    run_frame(8'h5A, 1'b1, 8'hFF, 1'b0, 0, 1, 8'hC3, 1'b0);
    run_frame(8'hC3, 1'b0, 8'hF0, 1'b1, 1, 0, '0, 1'b0);
    do_read();

    for (int n = 0; n < 40; n++) begin
      d  = DW'($urandom);
      t  = DW'($urandom);
      a  = 1'($urandom);
      ta = 1'($urandom);
      if ($urandom % 3 == 0) d = '1;
      run_frame(d, a, t, ta, 0, 0, '0, 1'b0);
      if ($urandom % 2 == 0) do_read();
      if ($urandom % 3 == 0) do_nak_clr();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule